// File: doc/BRIEF.md
# Parameter Memory Checksum Engine

This block walks a byte region of a small parameter memory and reduces it to a 16-bit checksum. A controller gives it a start address and a byte count and pulses `start`. The engine then reads the region one byte at a time through a read port with one cycle of latency. It pairs the bytes into big-endian 16-bit words and folds each word into a running value using a nibble-split update with fixed shift positions. When it finishes, it raises `done` for one cycle and presents the result on `crc`.

If the byte count is odd, the last byte is folded as the high half of a word whose low half is zero. When write-back is requested at start time, the engine stores the result into the same memory as two bytes at a chosen address, high byte first, before it signals completion. A typical use covers the 0xF8-byte parameter area that begins at address 0x00 and places the checksum at 0xFC.

Top module: `param_crc_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are 0 and `crc` is 0xFFFF.
- R2: The running value is seeded with 0xFFFF at each accepted start. For each word V and previous value P, with d = P^V, a = d[3:0] and b = d[7:4]^a, the new value is (P>>8) ^ (a<<3) ^ (a<<8) ^ b ^ (b<<7) ^ (b<<12), kept to 16 bits.
- R3: Each word is formed big-endian. The byte at the lower address goes to bits 15:8 and the byte at the next address goes to bits 7:0. Bytes are read exactly once each, at consecutive ascending addresses from the start address.
- R4: When the count is odd, the final byte is folded as {byte, 8'h00}.
- R5: A byte count of zero performs no memory reads and completes with `crc` = 0xFFFF.
- R6: `done` is high for exactly one cycle per accepted start. `busy` is high from the cycle after the start edge through the `done` cycle. `crc` holds its value after `done`.
- R7: With `wb_enable` high at start, the engine writes `crc[15:8]` to `wb_addr` and then `crc[7:0]` to `wb_addr`+1 in the next cycle, both before `done`. With `wb_enable` low at start, no write occurs.
- R8: A `start` pulse while `busy` is high is ignored. The running operation's reads and result are unchanged, and no extra `done` follows.
- R9: Read data is taken one cycle after `mem_rd_en`. A read and a write never occur in the same cycle.
- R10: For the 0xF8-byte region at address 0x00 with write-back at 0xFC, memory bytes 0xFC and 0xFD afterwards hold the high and low bytes of the reported checksum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| start_addr | input | AW | First byte address of the region |
| byte_count | input | AW | Number of bytes in the region |
| wb_addr | input | AW | Address of the high result byte for write-back |
| wb_enable | input | 1 | Store the result after computing it |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| crc | output | 16 | Checksum result |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Shared memory address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_data | output | 8 | Write data |

## Verification
The assertions assume that the memory responds to every read strobe with data on the next cycle. They also assume that `start` and the operand inputs are driven synchronously and only sampled while idle. The stimulus meets these assumptions with a byte-array memory model that registers each read, and by changing operands only on the falling edge. Regions and write-back addresses are chosen so that they stay inside the modelled array and do not overlap the region being summed.

// File: rtl/param_crc_engine.sv
module param_crc_engine #(
  parameter int AW = 16,
  parameter logic [15:0] SEED = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] byte_count,
  input  logic [AW-1:0] wb_addr,
  input  logic          wb_enable,
  output logic          busy,
  output logic          done,
  output logic [15:0]   crc,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          mem_wr_en,
  output logic [7:0]    mem_wr_data
);

  typedef enum logic [2:0] {
    S_IDLE, S_RHI, S_RLO, S_PAIR, S_WHI, S_WLO, S_DONE
  } state_t;

  state_t        st;
  logic [AW-1:0] ptr, remain, wb_a;
  logic          wb_on;
  logic [7:0]    hi_q;
  logic [15:0]   crc_q;

  function automatic logic [15:0] fold(input logic [15:0] p, input logic [15:0] v);
    logic [15:0] d, a, b;
    d = p ^ v;
    a = {12'h000, d[3:0]};
    b = {12'h000, d[7:4] ^ d[3:0]};
    return (p >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
  endfunction

  wire state_t post = wb_on ? S_WHI : S_DONE;
  wire last_odd = (remain == AW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      remain <= '0;
      wb_a   <= '0;
      wb_on  <= 1'b0;
      hi_q   <= '0;
      crc_q  <= SEED;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ptr    <= start_addr;
          remain <= byte_count;
          wb_a   <= wb_addr;
          wb_on  <= wb_enable;
          crc_q  <= SEED;
          if (byte_count == '0) st <= wb_enable ? S_WHI : S_DONE;
          else                  st <= S_RHI;
        end
        S_RHI: st <= S_RLO;
        S_RLO: begin
          hi_q <= mem_rd_data;
          if (last_odd) begin
            crc_q  <= fold(crc_q, {mem_rd_data, 8'h00});
            remain <= '0;
            st     <= post;
          end else begin
            st <= S_PAIR;
          end
        end
        S_PAIR: begin
          crc_q  <= fold(crc_q, {hi_q, mem_rd_data});
          ptr    <= ptr + AW'(2);
          remain <= remain - AW'(2);
          st     <= (remain == AW'(2)) ? post : S_RHI;
        end
        S_WHI:  st <= S_WLO;
        S_WLO:  st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign done        = (st == S_DONE);
  assign crc         = crc_q;
  assign mem_rd_en   = (st == S_RHI) || (st == S_RLO && !last_odd);
  assign mem_wr_en   = (st == S_WHI) || (st == S_WLO);
  assign mem_wr_data = (st == S_WHI) ? crc_q[15:8] : crc_q[7:0];
  assign mem_addr    = (st == S_WHI) ? wb_a :
                       (st == S_WLO) ? wb_a + AW'(1) :
                       (st == S_RLO) ? ptr + AW'(1) : ptr;

endmodule

// File: rtl/param_crc_engine_sva.sv
module param_crc_engine_sva #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [15:0]   crc,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_addr
);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_start_accepted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_crc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(crc));

  assert_no_rd_wr_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  assert_rd_in_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> (busy && !done));

  assert_rd_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  assert_wb_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_en) |=> (mem_wr_en && mem_addr == $past(mem_addr) + AW'(1)));

  assert_wb_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_en) |-> done);

endmodule

bind param_crc_engine param_crc_engine_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .crc(crc), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr)
);

// File: tb/param_crc_engine_test.sv
module param_crc_engine_test;
  localparam int PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0, byte_count = '0, wb_addr = '0;
  logic          wb_enable = 1'b0;
  logic          busy, done, mem_rd_en, mem_wr_en;
  logic [15:0]   crc;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rd_data = '0, mem_wr_data;

  logic [7:0] mem [256];
  int tests = 0, fails = 0;
  int rd_cnt, rd_bad, wr_cnt, done_cnt;
  logic [AW-1:0] exp_rd;

  always #(PERIOD/2) clk = ~clk;

  param_crc_engine #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .wb_addr(wb_addr), .wb_enable(wb_enable),
    .busy(busy), .done(done), .crc(crc), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_data(mem_wr_data)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem[mem_addr[7:0]];
      if (mem_addr != exp_rd) rd_bad++;
      exp_rd <= exp_rd + 1'b1;
      rd_cnt++;
    end
    if (mem_wr_en) begin
      mem[mem_addr[7:0]] <= mem_wr_data;
      wr_cnt++;
    end
    if (done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_step(input logic [15:0] p, input logic [15:0] v);
    logic [15:0] x;
    logic [3:0] lo, mix;
    x = p ^ v;
    lo = x[3:0];
    mix = x[7:4] ^ x[3:0];
    return {8'h00, p[15:8]} ^ {9'b0, lo, 3'b0} ^ {4'b0, lo, 8'b0} ^
           {12'b0, mix} ^ {5'b0, mix, 7'b0} ^ {mix, 12'b0};
  endfunction

  function automatic logic [15:0] ref_crc(input int sa, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i + 1 < n; i += 2) c = ref_step(c, {mem[sa+i], mem[sa+i+1]});
    if (n % 2) c = ref_step(c, {mem[sa+n-1], 8'h00});
    return c;
  endfunction

  task automatic launch(input int sa, input int n, input int wba, input bit wbe);
    @(negedge clk);
    rd_cnt = 0; rd_bad = 0; wr_cnt = 0; done_cnt = 0; exp_rd = AW'(sa);
    start_addr = AW'(sa); byte_count = AW'(n); wb_addr = AW'(wba); wb_enable = wbe;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 4000) begin @(negedge clk); k++; end
    chk(done, req, done, 1);
    @(negedge clk);
    chk(!done && !busy, "R6 pulse", {done, busy}, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !mem_rd_en && !mem_wr_en, "R1 idle", {busy, done, mem_rd_en, mem_wr_en}, 0);
    chk(crc == 16'hFFFF, "R1 crc", crc, 16'hFFFF);
  endtask

  task automatic t_zero;
    launch(8, 0, 0, 0);
    chk(done && busy, "R5 immediate", {done, busy}, 3);
    wait_done("R5 done");
    chk(crc == 16'hFFFF, "R5 crc", crc, 16'hFFFF);
    chk(rd_cnt == 0, "R5 no reads", rd_cnt, 0);
  endtask

  task automatic t_region(input int sa, input int n, input string req);
    logic [15:0] e = ref_crc(sa, n);
    launch(sa, n, 0, 0);
    chk(busy, "R6 busy", busy, 1);
    wait_done(req);
    chk(crc == e, req, crc, e);
    chk(rd_cnt == n && rd_bad == 0, "R3 reads", rd_cnt, n);
    chk(wr_cnt == 0, "R7 no write", wr_cnt, 0);
    repeat (3) @(negedge clk);
    chk(crc == e, "R6 hold", crc, e);
  endtask

  task automatic t_known;
    mem[200] = 8'h12; mem[201] = 8'h34;
    launch(200, 2, 0, 0);
    wait_done("R2 done");
    chk(crc == ref_step(16'hFFFF, 16'h1234), "R2 single word", crc, ref_step(16'hFFFF, 16'h1234));
    chk(crc != ref_step(16'hFFFF, 16'h3412), "R3 byte order", crc, 0);
  endtask

  task automatic t_standard;
    logic [15:0] e = ref_crc(0, 248);
    launch(0, 248, 252, 1);
    wait_done("R10 done");
    chk(crc == e, "R10 crc", crc, e);
    chk(mem[252] == e[15:8] && mem[253] == e[7:0], "R10 stored", {mem[252], mem[253]}, e);
    chk(wr_cnt == 2, "R7 writes", wr_cnt, 2);
  endtask

  task automatic t_wb_zero;
    launch(0, 0, 240, 1);
    wait_done("R7 zero wb");
    chk(mem[240] == 8'hFF && mem[241] == 8'hFF, "R7 zero wb data", {mem[240], mem[241]}, 16'hFFFF);
  endtask

  task automatic t_restart;
    logic [15:0] e = ref_crc(16, 20);
    launch(16, 20, 0, 0);
    repeat (3) @(negedge clk);
    start_addr = 100; byte_count = 7; wb_addr = 230; wb_enable = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R8 done");
    chk(crc == e, "R8 result", crc, e);
    chk(rd_cnt == 20 && rd_bad == 0, "R8 reads", rd_cnt, 20);
    chk(wr_cnt == 0, "R8 no wb", wr_cnt, 0);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1 && !busy, "R8 single done", done_cnt, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    exp_rd = '0; rd_cnt = 0; rd_bad = 0; wr_cnt = 0; done_cnt = 0;
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_zero;
    t_known;
    t_region(32, 8, "R2 even");
    t_region(64, 5, "R4 odd");
    t_region(90, 1, "R4 single byte");
    t_region(3, 33, "R3 unaligned odd");
    t_standard;
    t_wb_zero;
    t_restart;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule